// File: doc/BRIEF.md
# Odd-Weight-Column SEC-DED Codec (16 data bits, 6 check bits)

This block protects a 16-bit word with six check bits. The encoder is purely combinational. It forms each check bit as the XOR of a fixed subset of the data bits and returns a 22-bit codeword. The decoder accepts a possibly corrupted codeword together with a valid strobe. It recomputes the check bits from the received data and XORs them with the received check bits to form a 6-bit syndrome. The corrected data and two status flags appear on registered outputs one clock later.

Every column of the parity-check matrix has odd weight. The six check-bit columns are unit vectors. The sixteen data columns are distinct weight-3 patterns, chosen so that each check bit covers exactly eight data bits. A syndrome of odd weight therefore points to a single flipped bit. A nonzero syndrome of even weight can only come from an even number of flips. A memory controller places the encoder on its write path and the decoder on its read or scrub path.

Top module: `secded_codec`

## Requirements
- R1: Codeword layout is bits [15:0] data and bits [21:16] check; check bit j is the XOR of every data bit i whose column has bit j set. Data column i is the i-th smallest 6-bit value of weight 3 once the values 7, 11, 52 and 56 are excluded. Check bit j has column 1<<j.
- R2: Every codeword produced by the encoder has an even number of ones.
- R3: `dec_valid_o` is high in the cycle after `dec_valid_i` was sampled high and low otherwise; without a valid input, the data and flag outputs keep their values.
- R4: A codeword with zero syndrome returns its data bits unchanged, and neither flag is set.
- R5: A single flipped data bit is inverted back to its original value, and `dec_corrected_o` is set.
- R6: A single flipped check bit leaves the data output equal to the received data bits and sets `dec_corrected_o`.
- R7: A nonzero syndrome of even weight sets `dec_uncorrectable_o`, clears `dec_corrected_o`, and passes the received data bits through unchanged.
- R8: An odd-weight syndrome that equals no column (for example 7, or any weight-5 value) sets `dec_uncorrectable_o` and passes the received data bits through unchanged.
- R9: `dec_corrected_o` and `dec_uncorrectable_o` are never high together.
- R10: While reset is held, on the next clock edge all decoder outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_data_i | input | 16 | Data word to encode |
| enc_code_o | output | 22 | Encoded codeword (combinational) |
| dec_valid_i | input | 1 | Received codeword is valid this cycle |
| dec_code_i | input | 22 | Received codeword |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | 16 | Corrected (or passed-through) data |
| dec_corrected_o | output | 1 | A single-bit error was corrected |
| dec_uncorrectable_o | output | 1 | Error detected but not correctable |

## Verification
Data bits or check bits that are held or mapped wrongly show up in the same cycle as a bad encoder codeword. In the decoder they show up one cycle after the strobe, as a wrong data bit on an otherwise clean word. A wrong column constant or a wrong syndrome match appears as a miscorrected bit, or as the wrong flag, on the first word whose single error hits that column. For this reason every data and check position is flipped one at a time. A stale valid or hold register shows up on the first idle cycle after a result.

// File: rtl/secded_pkg.sv
// Package: code geometry and column generation for the SEC-DED codec.
// Assumes 6 check bits, so 20 weight-3 patterns exist and 16 are used.
package secded_pkg;
    localparam int DATA_W = 16;
    localparam int CHK_W  = 6;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int COL_WEIGHT = 3;

    // Purpose: count ones in a small value.
    function automatic int popcnt(input int v);
        int n;
        n = 0;
        for (int b = 0; b < CHK_W; b++) n += (v >> b) & 1;
        return n;
    endfunction

    // Purpose: two complementary pairs left out so each row covers 8 data bits.
    function automatic bit is_reserved(input int v);
        return (v == 7) || (v == 11) || (v == 52) || (v == 56);
    endfunction

    // Purpose: column of data bit idx in the parity-check matrix.
    function automatic logic [CHK_W-1:0] data_col(input int idx);
        int n;
        logic [CHK_W-1:0] col;
        n   = 0;
        col = '0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if (popcnt(v) == COL_WEIGHT && !is_reserved(v)) begin
                if (n == idx) col = CHK_W'(v);
                n++;
            end
        end
        return col;
    endfunction

    // Purpose: data bits that feed check bit row.
    function automatic logic [DATA_W-1:0] row_mask(input int row);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = data_col(i);
            m[i] = c[row];
        end
        return m;
    endfunction
endpackage

// File: rtl/secded_encoder.sv
// Module: combinational check-bit generator; one XOR tree per check bit.
// Assumes the row masks from secded_pkg; no state.
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam logic [DATA_W-1:0] MASK = row_mask(r);
        // Purpose: reduce the selected data bits for this row.
        always_comb check_o[r] = ^(data_i & MASK);
    end
endmodule

// File: rtl/secded_syndrome.sv
// Module: recomputes check bits from received data and compares them with
// the received check bits. Assumes layout {check, data}.
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syndrome_o
);
    logic [CHK_W-1:0] recomputed;

    secded_encoder u_enc (
        .data_i  (code_i[DATA_W-1:0]),
        .check_o (recomputed)
    );

    // Purpose: a mismatch in row r sets syndrome bit r.
    always_comb syndrome_o = recomputed ^ code_i[CODE_W-1:DATA_W];
endmodule

// File: rtl/secded_locate.sv
// Module: maps a syndrome to a data flip mask and the two status flags.
// Assumes odd-weight columns: even nonzero syndromes are never correctable.
module secded_locate
    import secded_pkg::*;
(
    input  logic [CHK_W-1:0]  syndrome_i,
    output logic [DATA_W-1:0] flip_o,
    output logic              corrected_o,
    output logic              uncorrectable_o
);
    logic [DATA_W-1:0] hit_data;
    logic [CHK_W-1:0]  hit_chk;
    logic              nonzero;
    logic              odd;
    logic              any_hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
        localparam logic [CHK_W-1:0] COL = data_col(i);
        // Purpose: match the syndrome against data column i.
        always_comb hit_data[i] = (syndrome_i == COL);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_ccol
        localparam logic [CHK_W-1:0] UNIT = CHK_W'(1) << j;
        // Purpose: match the syndrome against check column j.
        always_comb hit_chk[j] = (syndrome_i == UNIT);
    end

    // Purpose: classify the syndrome and build the flip mask.
    always_comb begin
        nonzero         = |syndrome_i;
        odd             = ^syndrome_i;
        any_hit         = (|hit_data) | (|hit_chk);
        corrected_o     = odd & any_hit;
        uncorrectable_o = nonzero & ~(odd & any_hit);
        flip_o          = hit_data;
    end
endmodule

// File: rtl/secded_codec.sv
// Module: SEC-DED codec top. Combinational encoder; decoder result is
// registered with one cycle of latency. Synchronous active-low reset.
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       enc_data_i,
    output logic [21:0]       enc_code_o,
    input  logic              dec_valid_i,
    input  logic [21:0]       dec_code_i,
    output logic              dec_valid_o,
    output logic [15:0]       dec_data_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorrectable_o
);
    logic [CHK_W-1:0]  enc_check;
    logic [CHK_W-1:0]  dec_syndrome;
    logic [DATA_W-1:0] dec_flip;
    logic              dec_corr_c;
    logic              dec_uncorr_c;

    secded_encoder u_encoder (
        .data_i  (enc_data_i),
        .check_o (enc_check)
    );

    // Purpose: assemble the outgoing codeword.
    always_comb enc_code_o = {enc_check, enc_data_i};

    secded_syndrome u_syndrome (
        .code_i     (dec_code_i),
        .syndrome_o (dec_syndrome)
    );

    secded_locate u_locate (
        .syndrome_i      (dec_syndrome),
        .flip_o          (dec_flip),
        .corrected_o     (dec_corr_c),
        .uncorrectable_o (dec_uncorr_c)
    );

    // Purpose: register decoder results; hold them while no word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o         <= 1'b0;
            dec_data_o          <= '0;
            dec_corrected_o     <= 1'b0;
            dec_uncorrectable_o <= 1'b0;
        end else begin
            dec_valid_o <= dec_valid_i;
            if (dec_valid_i) begin
                dec_data_o          <= dec_code_i[DATA_W-1:0] ^ dec_flip;
                dec_corrected_o     <= dec_corr_c;
                dec_uncorrectable_o <= dec_uncorr_c;
            end
        end
    end
endmodule

// File: rtl/secded_codec_chk.sv
// Module: assertion checker bound to secded_codec.
module secded_codec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [21:0] enc_code_o,
    input logic        dec_valid_i,
    input logic [21:0] dec_code_i,
    input logic        dec_valid_o,
    input logic [15:0] dec_data_o,
    input logic        dec_corrected_o,
    input logic        dec_uncorrectable_o,
    input logic [5:0]  syndrome
);
    a_r2_enc_even_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_code_o) == 1'b0);

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_corrected_o)
                         && $stable(dec_uncorrectable_o));

    a_r4_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && syndrome == 6'd0) |=>
        (dec_data_o == $past(dec_code_i[15:0])) && !dec_corrected_o && !dec_uncorrectable_o);

    a_r7_even_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && syndrome != 6'd0 && !(^syndrome)) |=>
        dec_uncorrectable_o && (dec_data_o == $past(dec_code_i[15:0])));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected_o && dec_uncorrectable_o));
endmodule

bind secded_codec secded_codec_chk u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .enc_code_o          (enc_code_o),
    .dec_valid_i         (dec_valid_i),
    .dec_code_i          (dec_code_i),
    .dec_valid_o         (dec_valid_o),
    .dec_data_o          (dec_data_o),
    .dec_corrected_o     (dec_corrected_o),
    .dec_uncorrectable_o (dec_uncorrectable_o),
    .syndrome            (dec_syndrome)
);

// File: tb/secded_codec_test.sv
`timescale 1ns/1ps
module secded_codec_test;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] enc_data_i = '0;
    logic [21:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [21:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [15:0] dec_data_o;
    logic        dec_corrected_o;
    logic        dec_uncorrectable_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    secded_codec uut (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_corrected_o(dec_corrected_o), .dec_uncorrectable_o(dec_uncorrectable_o)
    );

    // Column list from R1, built independently.
    function automatic logic [5:0] m_col(input int idx);
        int n = 0;
        logic [5:0] r = '0;
        for (int v = 0; v < 64; v++) begin
            if ($countones(6'(v)) == 3 && v != 7 && v != 11 && v != 52 && v != 56) begin
                if (n == idx) r = 6'(v);
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [21:0] m_encode(input logic [15:0] d);
        logic [5:0] c = '0;
        for (int i = 0; i < 16; i++) if (d[i]) c ^= m_col(i);
        return {c, d};
    endfunction

    // Expected decode from R4-R8: {data, corrected, uncorrectable}.
    function automatic logic [17:0] m_decode(input logic [21:0] w);
        logic [21:0] ref_w = m_encode(w[15:0]);
        logic [5:0]  s = ref_w[21:16] ^ w[21:16];
        logic [15:0] d = w[15:0];
        bit hit = 0;
        if (s == 0) return {d, 2'b00};
        if (^s) begin
            for (int i = 0; i < 16; i++) if (s == m_col(i)) begin d[i] = ~d[i]; hit = 1; end
            for (int j = 0; j < 6; j++) if (s == (6'd1 << j)) hit = 1;
        end
        return hit ? {d, 2'b10} : {w[15:0], 2'b01};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_enc(input logic [15:0] d);
        logic [21:0] e = m_encode(d);
        @(negedge clk);
        enc_data_i = d;
        #1;
        check(enc_code_o == e, "R1", "encode", 32'(enc_code_o), 32'(e));
        check((^enc_code_o) == 1'b0, "R2", "even weight", 32'(^enc_code_o), 0);
    endtask

    task automatic run_dec(input logic [21:0] w, input string req);
        logic [17:0] e = m_decode(w);
        @(negedge clk);
        dec_code_i  = w;
        dec_valid_i = 1'b1;
        @(negedge clk);
        dec_valid_i = 1'b0;
        check(dec_valid_o == 1'b1, "R3", "valid after strobe", 32'(dec_valid_o), 1);
        check({dec_data_o, dec_corrected_o, dec_uncorrectable_o} == e, req, "decode",
              32'({dec_data_o, dec_corrected_o, dec_uncorrectable_o}), 32'(e));
        check(!(dec_corrected_o && dec_uncorrectable_o), "R9", "flags exclusive",
              32'({dec_corrected_o, dec_uncorrectable_o}), 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [21:0] w;
        logic [17:0] last;
        void'($urandom(32'h5EC0_DED1));
        dec_code_i  = 22'h3FFFFF;
        repeat (3) @(negedge clk);
        // R10: reset state
        check({dec_valid_o, dec_data_o, dec_corrected_o, dec_uncorrectable_o} == 0,
              "R10", "reset outputs",
              32'({dec_valid_o, dec_data_o, dec_corrected_o, dec_uncorrectable_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: directed and random encodes
        check_enc(16'h0000);
        check_enc(16'hFFFF);
        for (int i = 0; i < 16; i++) check_enc(16'd1 << i);
        for (int k = 0; k < 200; k++) check_enc(16'($urandom));

        // R4: clean words
        run_dec(m_encode(16'h0000), "R4");
        run_dec(m_encode(16'hFFFF), "R4");
        run_dec(m_encode(16'hA5C3), "R4");

        // R3: idle cycle leaves outputs unchanged and valid low
        last = {dec_data_o, dec_corrected_o, dec_uncorrectable_o};
        @(negedge clk);
        dec_code_i = 22'h155555;
        @(negedge clk);
        check(dec_valid_o == 1'b0, "R3", "idle valid", 32'(dec_valid_o), 0);
        check({dec_data_o, dec_corrected_o, dec_uncorrectable_o} == last, "R3", "idle hold",
              32'({dec_data_o, dec_corrected_o, dec_uncorrectable_o}), 32'(last));

        // R5: every single data-bit flip
        for (int i = 0; i < 16; i++) run_dec(m_encode(16'h3C96) ^ (22'd1 << i), "R5");
        // R6: every single check-bit flip
        for (int j = 0; j < 6; j++) run_dec(m_encode(16'h3C96) ^ (22'd1 << (16 + j)), "R6");
        // R7: double flips
        run_dec(m_encode(16'h1234) ^ 22'h000003, "R7");
        run_dec(m_encode(16'h1234) ^ 22'h210000, "R7");
        run_dec(m_encode(16'h1234) ^ 22'h018000, "R7");
        // R8: odd syndromes that equal no column (7 and weight 5)
        run_dec(m_encode(16'hBEEF) ^ {6'b000111, 16'h0}, "R8");
        run_dec(m_encode(16'hBEEF) ^ {6'b011111, 16'h0}, "R8");

        // Random mix of 0..3 injected errors
        for (int k = 0; k < 1500; k++) begin
            int nerr = int'($urandom_range(0, 3));
            w = m_encode(16'($urandom));
            for (int e = 0; e < nerr; e++) w[$urandom_range(0, 21)] ^= 1'b1;
            run_dec(w, nerr == 0 ? "R4" : (nerr == 1 ? "R5" : (nerr == 2 ? "R7" : "R8")));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule